// File: doc/BRIEF.md
# Segment LCD Drive Level Sequencer

This block generates the drive waveforms for a segment LCD panel with up to 64 segment pins and one to four common pins. It does not produce voltages. It produces a 2-bit level code for every common and segment pin, and an external bias network turns each code into one of four equally spaced voltages. A pixel sees the common level minus the segment level.

The block holds a pixel store with one bit for each common/segment pair. A 1 means the pixel is dark and a 0 means it is clear. The input clock passes through a fixed divider and then a programmable prescaler. Each prescaler terminal count ends one time slot.

In type A mode, each common gets two consecutive slots of opposite polarity. In type B mode, each common gets one slot per frame and the polarity flips at every frame boundary. With either mode every pixel averages to zero DC. Segment pins whose enable bit is clear are released to general I/O.

Top module: `lcd_wavegen`

## Requirements
- R1: A pixel store write (`wr_en` with `wr_com`, `wr_seg`, `wr_val`) changes the driven levels from the clock edge that takes it. The written bit then applies whenever `wr_com` is the active common.
- R2: With two or more commons, in the positive half the active common is code 3 and the other used commons are code 1. An enabled segment is code 0 when its pixel bit is 1 and code 2 when it is 0.
- R3: In the inverted half, every code from R2 is replaced by its complement, so 3 becomes 0 and 2 becomes 1.
- R4: With `mux_sel` = 0 (static, one common), common 0 is code 3 in the positive half and code 0 in the inverted half. A dark segment takes the opposite code to the common and a clear segment takes the same code.
- R5: With `wave_b` = 0, the sequence is common 0 positive, common 0 inverted, common 1 positive, and so on up to common `mux_sel`, and then it wraps.
- R6: With `wave_b` = 1, each common from 0 to `mux_sel` gets one slot. The polarity flips each time the sequence wraps back to common 0.
- R7: Each slot lasts FIXDIV × (`prescale` + 1) clock cycles. The first slot after a start is counted from the first running edge.
- R8: A segment pin whose `seg_en` bit is 0 carries code 0 and has `seg_oe` low. An enabled pin has `seg_oe` high while running.
- R9: While not running, after reset, and whenever `enable` is low, all levels are code 0 and `seg_oe` is all zeros. The next start begins at common 0, positive half.
- R10: With `sleep_req` high, the block stops as in R9 unless `run_in_sleep` is high, in which case it keeps sequencing.
- R11: Commons numbered above `mux_sel` stay at code 0 while running.
- R12: Summed over one frame in type A mode, or over two frames in type B mode, the per-cycle difference (common code − segment code) of every used pixel is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Starts and stops generation |
| sleep_req | input | 1 | Sleep request |
| run_in_sleep | input | 1 | Keep generating during sleep |
| mux_sel | input | CW | Highest used common index (0 = static) |
| wave_b | input | 1 | 0 = invert per slot, 1 = invert per frame |
| prescale | input | PSW | Frame prescaler, slot = FIXDIV × (prescale + 1) cycles |
| seg_en | input | NSEG | Per-pin segment drive enable |
| wr_en | input | 1 | Pixel store write strobe |
| wr_com | input | CW | Common index of the write |
| wr_seg | input | SW | Segment index of the write |
| wr_val | input | 1 | Pixel value, 1 = dark |
| com_lvl | output | 2×NCOM | Level code per common, pin c at bits [2c+1:2c] |
| seg_lvl | output | 2×NSEG | Level code per segment, pin s at bits [2s+1:2s] |
| seg_oe | output | NSEG | Segment pin driven (0 = general I/O) |

## Verification
The levels are combinational from the sequencer state, the pixel store and the mode inputs. A change of `enable`, `sleep_req`, `seg_en` or mode therefore shows before the next edge. A pixel write shows one edge after it is presented. A slot change shows at the FIXDIV × (`prescale` + 1)-th running edge.

A behavioural model counts running edges and advances at that same edge. The bench compares all outputs 2 ns after every rising edge. The explicit window checks sample 2 ns after each falling edge, beginning in the cycle the block starts. One slot therefore spans exactly FIXDIV × (`prescale` + 1) samples.

// File: rtl/lcd_wavegen.sv
module lcd_wavegen #(
  parameter int NSEG   = 64,
  parameter int NCOM   = 4,
  parameter int FIXDIV = 8192,
  parameter int PSW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                sleep_req,
  input  logic                run_in_sleep,
  input  logic [((NCOM>1)?$clog2(NCOM):1)-1:0] mux_sel,
  input  logic                wave_b,
  input  logic [PSW-1:0]      prescale,
  input  logic [NSEG-1:0]     seg_en,
  input  logic                wr_en,
  input  logic [((NCOM>1)?$clog2(NCOM):1)-1:0] wr_com,
  input  logic [$clog2(NSEG)-1:0] wr_seg,
  input  logic                wr_val,
  output logic [2*NCOM-1:0]   com_lvl,
  output logic [2*NSEG-1:0]   seg_lvl,
  output logic [NSEG-1:0]     seg_oe
);
  localparam int CW = (NCOM > 1) ? $clog2(NCOM) : 1;
  localparam int DW = (FIXDIV > 1) ? $clog2(FIXDIV) : 1;

  logic [NSEG-1:0] pix [NCOM];
  logic [DW-1:0]   div_q;
  logic [PSW-1:0]  pre_q;
  logic [CW-1:0]   com_q;
  logic            inv_q;

  wire running = enable & ~(sleep_req & ~run_in_sleep);
  wire tick    = div_q == DW'(FIXDIV - 1);
  wire pre_end = pre_q >= prescale;
  wire step    = running & tick & pre_end;
  wire last    = com_q >= mux_sel;
  wire stat    = mux_sel == '0;
  wire [CW-1:0] com_nx = last ? '0 : com_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q <= '0; pre_q <= '0; com_q <= '0; inv_q <= 1'b0;
    end else if (!running) begin
      div_q <= '0; pre_q <= '0; com_q <= '0; inv_q <= 1'b0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) pre_q <= pre_end ? '0 : pre_q + 1'b1;
      if (step) begin
        if (wave_b) begin
          com_q <= com_nx;
          if (last) inv_q <= ~inv_q;
        end else begin
          inv_q <= ~inv_q;
          if (inv_q) com_q <= com_nx;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int c = 0; c < NCOM; c++) pix[c] <= '0;
    end else if (wr_en) begin
      pix[wr_com][wr_seg] <= wr_val;
    end

  always_comb begin
    for (int c = 0; c < NCOM; c++) begin
      logic [1:0] lv;
      lv = 2'd0;
      if (running && CW'(c) <= mux_sel) begin
        lv = (stat || CW'(c) == com_q) ? 2'd3 : 2'd1;
        if (inv_q) lv = ~lv;
      end
      com_lvl[2*c +: 2] = lv;
    end
    for (int s = 0; s < NSEG; s++) begin
      logic [1:0] lv;
      lv = 2'd0;
      if (running && seg_en[s]) begin
        if (pix[com_q][s]) lv = 2'd0;
        else               lv = stat ? 2'd3 : 2'd2;
        if (inv_q) lv = ~lv;
      end
      seg_lvl[2*s +: 2] = lv;
    end
  end

  assign seg_oe = running ? seg_en : '0;

  p_idle_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (com_q == '0 && !inv_q && div_q == '0));
  p_slot_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (div_q == '0 && pre_q == '0));
  p_flip_each_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wave_b) |=> inv_q != $past(inv_q));
  p_flip_at_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wave_b && last) |=> (com_q == '0 && inv_q != $past(inv_q)));
  p_com_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> com_q <= $past(mux_sel));
endmodule

// File: tb/sim_lcd_wavegen.sv
module sim_lcd_wavegen;
  localparam int NS = 8, NC = 4, FD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, slp = 0, keep = 0, wb = 0, wr = 0, wv = 0;
  logic [1:0] mux = 0, wc = 0;
  logic [2:0] ws = 0;
  logic [3:0] ps = 0;
  logic [NS-1:0] sen = 0;
  logic [2*NC-1:0] com_lvl;
  logic [2*NS-1:0] seg_lvl;
  logic [NS-1:0] seg_oe;

  int n_chk = 0, n_bad = 0;
  bit cmp_on = 0, done = 0;
  int m_cnt = 0, m_com = 0, m_inv = 0;
  bit m_pix [NC][NS];

  always #5 clk = ~clk;

  lcd_wavegen #(.NSEG(NS), .NCOM(NC), .FIXDIV(FD), .PSW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(en), .sleep_req(slp), .run_in_sleep(keep),
    .mux_sel(mux), .wave_b(wb), .prescale(ps), .seg_en(sen), .wr_en(wr),
    .wr_com(wc), .wr_seg(ws), .wr_val(wv), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
    .seg_oe(seg_oe));

  function automatic bit mrun();
    return en && !(slp && !keep);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference sequencer: counts running edges, advances per R5/R6/R7
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_com = 0; m_inv = 0;
      foreach (m_pix[c, s]) m_pix[c][s] = 0;
    end else begin
      if (wr) m_pix[wc][ws] = wv;
      if (!mrun()) begin
        m_cnt = 0; m_com = 0; m_inv = 0;
      end else begin
        m_cnt++;
        if (m_cnt == FD * (ps + 1)) begin
          m_cnt = 0;
          if (wb) begin
            if (m_com >= mux) begin m_com = 0; m_inv ^= 1; end
            else m_com++;
          end else if (m_inv == 0) m_inv = 1;
          else begin
            m_inv = 0;
            m_com = (m_com >= mux) ? 0 : m_com + 1;
          end
        end
      end
    end
  end

  function automatic int exp_com(int c);
    int lv;
    if (!mrun() || c > mux) return 0;
    if (mux == 0) lv = 3;
    else lv = (c == m_com) ? 3 : 1;
    return m_inv ? 3 - lv : lv;
  endfunction

  function automatic int exp_seg(int s);
    int lv;
    if (!mrun() || !sen[s]) return 0;
    if (m_pix[m_com][s]) lv = 0;
    else lv = (mux == 0) ? 3 : 2;
    return m_inv ? 3 - lv : lv;
  endfunction

  function automatic string com_tag(int c);
    if (!mrun()) return "R9";
    if (c > mux) return "R11";
    if (mux == 0) return "R4";
    return m_inv ? "R3" : "R2";
  endfunction

  function automatic string seg_tag(int s);
    if (!mrun()) return "R9";
    if (!sen[s]) return "R8";
    if (mux == 0) return "R4";
    return m_inv ? "R3/R1" : "R2/R1";
  endfunction

  always @(posedge clk) begin
    #2;
    if (cmp_on) begin
      for (int c = 0; c < NC; c++) check(com_tag(c), com_lvl[2*c +: 2], exp_com(c));
      for (int s = 0; s < NS; s++) check(seg_tag(s), seg_lvl[2*s +: 2], exp_seg(s));
      check("R8 seg_oe", seg_oe, mrun() ? sen : 0);
    end
  end

  task automatic write_pix(input int c, input int s, input bit v);
    @(negedge clk);
    wr = 1; wc = c[1:0]; ws = s[2:0]; wv = v;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic start(input int m, input bit b, input int p);
    @(negedge clk);
    en = 0;
    @(negedge clk);
    mux = m[1:0]; wb = b; ps = p[3:0]; en = 1;
    #2;
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic dc_run(input int m, input bit b, input int p);
    int acc [NC][NS];
    int w;
    foreach (acc[c, s]) acc[c][s] = 0;
    w = 2 * (m + 1) * FD * (p + 1);
    start(m, b, p);
    for (int k = 0; k < w; k++) begin
      for (int c = 0; c <= m; c++)
        for (int s = 0; s < NS; s++)
          if (sen[s]) acc[c][s] += int'(com_lvl[2*c +: 2]) - int'(seg_lvl[2*s +: 2]);
      adv(1);
    end
    for (int c = 0; c <= m; c++)
      for (int s = 0; s < NS; s++)
        if (sen[s]) check($sformatf("R12 dc m=%0d b=%0d c%0d s%0d", m, b, c, s), acc[c][s], 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic [2*NC-1:0] first;
    repeat (3) @(negedge clk);
    #2;
    check("R9 reset com", com_lvl, 0);
    check("R9 reset seg", seg_lvl, 0);
    check("R9 reset oe", seg_oe, 0);
    @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    sen = 8'b1011_1111;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++)
        write_pix(c, s, ((c + s) % 3 == 0) || (s == 4));

    // R7 slot length and R5 type A order, mux=1, prescale=1
    start(1, 0, 1);
    check("R2 active com0 positive", com_lvl[1:0], 3);
    check("R2 idle com1 positive", com_lvl[3:2], 1);
    first = com_lvl;
    cnt = 0;
    while (com_lvl == first && cnt < 100) begin adv(1); cnt++; end
    check("R7 slot cycles", cnt, FD * 2);
    check("R5 com0 inverted half", com_lvl[1:0], 0);
    check("R5 com1 inverted half", com_lvl[3:2], 2);
    check("R11 com2 unused", com_lvl[5:4], 0);
    adv(FD * 2);
    check("R5 com1 active next", com_lvl[3:2], 3);

    // R6 type B order, mux=1, prescale=0
    start(1, 1, 0);
    adv(FD);
    check("R6 com1 active frame0", com_lvl[3:2], 3);
    check("R6 com0 idle frame0", com_lvl[1:0], 1);
    adv(FD);
    check("R6 com0 active frame1 inverted", com_lvl[1:0], 0);
    check("R6 com1 idle frame1 inverted", com_lvl[3:2], 2);

    // R1 write takes effect on next edge, long slot
    start(2, 0, 15);
    write_pix(0, 1, 1);
    check("R1 seg1 dark", seg_lvl[3:2], 0);
    write_pix(0, 1, 0);
    check("R1 seg1 clear", seg_lvl[3:2], 2);
    check("R8 disabled seg6 level", seg_lvl[13:12], 0);
    check("R8 disabled seg6 oe", seg_oe[6], 0);

    // R4 static levels
    write_pix(0, 0, 1);
    write_pix(0, 2, 0);
    start(0, 0, 0);
    check("R4 static com pos", com_lvl[1:0], 3);
    check("R4 static dark seg pos", seg_lvl[1:0], 0);
    check("R4 static clear seg pos", seg_lvl[5:4], 3);
    adv(FD);
    check("R4 static com inv", com_lvl[1:0], 0);
    check("R4 static dark seg inv", seg_lvl[1:0], 3);

    // R10 sleep behaviour
    start(3, 0, 0);
    adv(FD + 1);
    @(negedge clk);
    slp = 1; keep = 0;
    #2;
    check("R10 sleep stop com", com_lvl, 0);
    check("R10 sleep stop oe", seg_oe, 0);
    @(negedge clk);
    keep = 1;
    #2;
    check("R10 sleep run restarts com0", com_lvl[1:0], 3);
    adv(FD);
    check("R10 sleep run advances", com_lvl[1:0], 0);
    @(negedge clk);
    slp = 0; keep = 0;

    // R9 disable mid run then restart
    @(negedge clk);
    en = 0;
    #2;
    check("R9 disabled com", com_lvl, 0);
    @(negedge clk);
    en = 1;
    #2;
    check("R9 restart com0 positive", com_lvl[1:0], 3);

    // R12 zero net DC
    dc_run(3, 0, 0);
    dc_run(3, 1, 1);
    dc_run(2, 1, 0);
    dc_run(0, 0, 0);
    dc_run(0, 1, 2);
    dc_run(1, 0, 1);

    @(negedge clk);
    en = 0;
    adv(2);
    cmp_on = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule